// File: doc/BRIEF.md
# Signed Array Multiplier with Inverted-Bit Sign Handling

This block multiplies two signed two's-complement operands of `N` bits each and gives the exact signed product of `2N` bits. It does not sign-extend partial-product rows and it does not negate either operand. Each bit in the rectangular array of AND terms that carries negative weight is replaced by its NAND. A constant one goes into column `N`. The top bit of the final sum is then flipped. Each row enters a chain of 3:2 carry-save stages, and a ripple carry-propagate adder joins the last sum and carry vectors.

The arithmetic core has no state. After it, a `PIPE_STAGES`-deep register pipeline with valid/ready flow control carries results out. An operand pair is taken on a rising edge where `in_valid` and `in_ready` are both high. A result leaves on a rising edge where `out_valid` and `out_ready` are both high. Back-pressure works like this: while `out_ready` is low, a valid output stays frozen. The pipeline then fills. Once every stage is full, `in_ready` goes low. A consumer that holds `out_ready` high never stalls the producer.

Top module: `bwm_signed_mult`

## Requirements
- R1: `out_product` equals the two's-complement product of `in_a` and `in_b`, each taken as a signed `N`-bit value. This holds for every operand pair, and the product bits are sign bit first, `2N` bits wide.
- R2: The most negative operand times itself gives +2^(2N-2). For N=8 this is 0x4000.
- R3: Results leave in the order their operands were accepted. While `out_ready` stays high, a pair accepted on edge k leaves on edge k+`PIPE_STAGES`.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_product` does not change.
- R5: `in_ready` is high whenever `out_ready` is high. `in_ready` goes low only when every pipeline stage holds a result.
- R6: After reset, `out_valid` is low and `in_ready` is high.
- R7: A cycle with `in_valid` low transfers nothing. Each accepted pair gives exactly one output transfer, and no output appears for cycles with nothing accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operand pair is present |
| in_ready | output | 1 | The block can accept an operand pair |
| in_a | input | N | Signed multiplicand |
| in_b | input | N | Signed multiplier |
| out_valid | output | 1 | A product is present |
| out_ready | input | 1 | The consumer accepts the product |
| out_product | output | 2N | Signed product |

## Verification
With `out_ready` held high, each product leaves exactly `PIPE_STAGES` rising edges after its operands were accepted. The bench tags every accepted pair with the index of its edge and checks that distance for the stall-free phases. Both sides are sampled one nanosecond before each rising edge, once the inputs driven at the previous falling edge have settled. Each output handshake is paired in order with the oldest pending input handshake. This lets the random valid/ready phase check order, data and count without depending on latency. A frozen output seen in one cycle is compared again in the next cycle in which it is still stalled.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  // single-bit full adder terms used by the carry-save and ripple stages
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/bwm_pp_gen.sv
module bwm_pp_gen #(
  parameter int N = 8
) (
  input  logic [N-1:0]            op_a,
  input  logic [N-1:0]            op_b,
  output logic [N-1:0][2*N-1:0]   rows
);
  localparam int W = 2 * N;

  // row j holds a_i & b_j at column i+j; bits with exactly one sign index negate to NAND
  always_comb begin
    rows = '0;
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        if ((i == N - 1) != (j == N - 1))
          rows[j][i + j] = ~(op_a[i] & op_b[j]);
        else
          rows[j][i + j] = op_a[i] & op_b[j];
      end
    end
  end
endmodule

// File: rtl/bwm_csa_array.sv
module bwm_csa_array #(
  parameter int W   = 16,
  parameter int OPS = 9
) (
  input  logic [OPS-1:0][W-1:0] ops,
  output logic [W-1:0]          sum_vec,
  output logic [W-1:0]          car_vec
);
  import bwm_pkg::*;

  localparam int LVL = OPS - 2;

  logic [LVL:0][W-1:0] sv;
  logic [LVL:0][W-1:0] cv;
  logic [LVL:0][W-1:0] cy;

  assign sv[0] = ops[0];
  assign cv[0] = ops[1];
  assign cy[0] = '0;

  genvar k, x;
  generate
    for (k = 1; k <= LVL; k++) begin : g_lvl
      for (x = 0; x < W; x++) begin : g_bit
        assign sv[k][x] = fa_sum(sv[k-1][x], cv[k-1][x], ops[k+1][x]);
        assign cy[k][x] = fa_carry(sv[k-1][x], cv[k-1][x], ops[k+1][x]);
      end
      assign cv[k] = {cy[k][W-2:0], 1'b0};
    end
  endgenerate

  assign sum_vec = sv[LVL];
  assign car_vec = cv[LVL];
endmodule

// File: rtl/bwm_cpa.sv
module bwm_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] s_out
);
  import bwm_pkg::*;

  logic [W-1:0] c;
  assign c[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_rip
      assign s_out[i] = fa_sum(x_in[i], y_in[i], c[i]);
      if (i < W - 1) begin : g_c
        assign c[i+1] = fa_carry(x_in[i], y_in[i], c[i]);
      end
    end
  endgenerate
endmodule

// File: rtl/bwm_pipe.sv
module bwm_pipe #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_valid,
  output logic         src_ready,
  input  logic [W-1:0] src_data,
  output logic         dst_valid,
  input  logic         dst_ready,
  output logic [W-1:0] dst_data
);
  logic [STAGES:0]        v;
  logic [STAGES:0][W-1:0] d;
  logic [STAGES:0]        rdy;

  assign v[0]        = src_valid;
  assign d[0]        = src_data;
  assign rdy[STAGES] = dst_ready;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      assign rdy[k] = ~v[k+1] | rdy[k+1];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v[k+1] <= 1'b0;
          d[k+1] <= '0;
        end else if (rdy[k]) begin
          v[k+1] <= v[k];
          if (v[k]) d[k+1] <= d[k];
        end
      end
    end
  endgenerate

  assign src_ready = rdy[0];
  assign dst_valid = v[STAGES];
  assign dst_data  = d[STAGES];
endmodule

// File: rtl/bwm_signed_mult.sv
module bwm_signed_mult #(
  parameter int N           = 8,
  parameter int PIPE_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   in_a,
  input  logic [N-1:0]   in_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*N-1:0] out_product
);
  localparam int W   = 2 * N;
  localparam int OPS = N + 1;

  logic [N-1:0][W-1:0]   pp_rows;
  logic [OPS-1:0][W-1:0] ops;
  logic [W-1:0]          cs_sum, cs_car, raw_sum, prod_comb;

  bwm_pp_gen #(.N(N)) pp_i (
    .op_a (in_a),
    .op_b (in_b),
    .rows (pp_rows)
  );

  // the last operand is the fixed one in column N
  always_comb begin
    for (int r = 0; r < N; r++) ops[r] = pp_rows[r];
    ops[N]    = '0;
    ops[N][N] = 1'b1;
  end

  bwm_csa_array #(.W(W), .OPS(OPS)) csa_i (
    .ops     (ops),
    .sum_vec (cs_sum),
    .car_vec (cs_car)
  );

  bwm_cpa #(.W(W)) cpa_i (
    .x_in  (cs_sum),
    .y_in  (cs_car),
    .s_out (raw_sum)
  );

  assign prod_comb = {~raw_sum[W-1], raw_sum[W-2:0]};

  bwm_pipe #(.W(W), .STAGES(PIPE_STAGES)) pipe_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (in_valid),
    .src_ready (in_ready),
    .src_data  (prod_comb),
    .dst_valid (out_valid),
    .dst_ready (out_ready),
    .dst_data  (out_product)
  );
endmodule

// File: rtl/bwm_signed_mult_chk.sv
module bwm_signed_mult_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [N-1:0]   in_a,
  input logic [N-1:0]   in_b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*N-1:0] out_product,
  input logic [2*N-1:0] comb_prod
);
  localparam int W = 2 * N;

  logic signed [W-1:0] ref_p;
  assign ref_p = $signed({{N{in_a[N-1]}}, in_a}) * $signed({{N{in_b[N-1]}}, in_b});

  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (comb_prod == ref_p)); // R1

  AST_MIN_SQUARED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a == {1'b1, {(N-1){1'b0}}} && in_b == {1'b1, {(N-1){1'b0}}})
      |-> (comb_prod == {2'b01, {(W-2){1'b0}}})); // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_product))); // R4

  AST_READY_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready); // R5
endmodule

bind bwm_signed_mult bwm_signed_mult_chk #(.N(N)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_product (out_product),
  .comb_prod   (prod_comb)
);

// File: tb/bwm_signed_mult_tb_top.sv
module bwm_signed_mult_tb_top;
  localparam int N    = 8;
  localparam int PIPE = 2;
  localparam int W    = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N-1:0] in_a = '0;
  logic [N-1:0] in_b = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_product;

  always #5 clk = ~clk;

  bwm_signed_mult #(.N(N), .PIPE_STAGES(PIPE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_product(out_product)
  );

  int n_chk = 0;
  int n_bad = 0;
  int edge_no = 0;
  int wr_ptr = 0;
  int rd_ptr = 0;
  bit nostall = 1'b1;
  bit done = 1'b0;
  bit held_flag = 1'b0;
  logic [W-1:0] held_val;

  logic [N-1:0] q_a [16];
  logic [N-1:0] q_b [16];
  int           q_e [16];
  bit           q_n [16];

  function automatic logic [W-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    int x, y, p;
    x = (a[N-1]) ? int'(a) - (1 << N) : int'(a);
    y = (b[N-1]) ? int'(b) - (1 << N) : int'(b);
    p = x * y;
    return p[W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample just before rising edge
  task automatic cycle(input bit v, input logic [N-1:0] a, input logic [N-1:0] b, input bit r);
    int idx;
    logic [W-1:0] exp_p;
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; out_ready = r;
    #4;
    if (held_flag) begin
      check(out_valid == 1'b1, "R4 valid held", int'(out_valid), 1);
      check(out_product == held_val, "R4 data held", int'(out_product), int'(held_val));
      held_flag = 1'b0;
    end
    if (out_ready) check(in_ready == 1'b1, "R5 ready pass", int'(in_ready), 1);
    if (out_valid && !out_ready) begin
      held_flag = 1'b1;
      held_val = out_product;
    end
    if (in_valid && in_ready) begin
      idx = wr_ptr % 16;
      q_a[idx] = in_a; q_b[idx] = in_b; q_e[idx] = edge_no; q_n[idx] = nostall;
      wr_ptr++;
    end
    if (out_valid && out_ready) begin
      if (rd_ptr >= wr_ptr) begin
        check(1'b0, "R7 spurious output", rd_ptr, wr_ptr);
      end else begin
        idx = rd_ptr % 16;
        exp_p = ref_mul(q_a[idx], q_b[idx]);
        if (q_a[idx] == {1'b1, {(N-1){1'b0}}} && q_b[idx] == {1'b1, {(N-1){1'b0}}})
          check(out_product == 16'h4000, "R2 min squared", int'(out_product), 'h4000);
        else
          check(out_product == exp_p, "R1 product", int'(out_product), int'(exp_p));
        if (q_n[idx])
          check(edge_no - q_e[idx] == PIPE, "R3 latency", edge_no - q_e[idx], PIPE);
        rd_ptr++;
      end
    end
    edge_no++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R6 reset valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R6 reset ready", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    #4;
    check(out_valid == 1'b0, "R6 post-reset valid", int'(out_valid), 0);

    // directed corners, ready held high (R1, R2, R3)
    cycle(1'b1, 8'h80, 8'h80, 1'b1);
    cycle(1'b1, 8'h80, 8'h7f, 1'b1);
    cycle(1'b1, 8'hff, 8'hff, 1'b1);
    cycle(1'b1, 8'h7f, 8'h7f, 1'b1);
    cycle(1'b1, 8'h00, 8'h80, 1'b1);
    cycle(1'b1, 8'h01, 8'hff, 1'b1);

    // exhaustive sweep of all pairs (R1, R3)
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        cycle(1'b1, i[N-1:0], j[N-1:0], 1'b1);
    for (int k = 0; k < 4; k++) cycle(1'b0, 8'h00, 8'h00, 1'b1);

    // random valid/ready mix (R4, R5, R7)
    nostall = 1'b0;
    begin
      int unsigned seed_v;
      seed_v = $urandom(32'd1234);
      for (int k = 0; k < 6000; k++) begin
        bit v, r;
        v = ($urandom % 10) < 7;
        r = ($urandom % 10) < 6;
        cycle(v, N'($urandom), N'($urandom), r);
      end
    end

    // stall until full, with pending input: in_ready must drop (R5)
    cycle(1'b1, 8'h05, 8'hfb, 1'b0);
    cycle(1'b1, 8'h06, 8'hfa, 1'b0);
    cycle(1'b1, 8'h07, 8'hf9, 1'b0);
    check(in_ready == 1'b0, "R5 full stall", int'(in_ready), 0);

    // drain with idle inputs; counts must match (R7)
    for (int k = 0; k < 10; k++) cycle(1'b0, 8'h5a, 8'ha5, 1'b1);
    check(rd_ptr == wr_ptr, "R7 transfer count", rd_ptr, wr_ptr);
    check(out_valid == 1'b0, "R7 idle output", int'(out_valid), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule